// File: doc/BRIEF.md
# Floating-Point Register High-Half Mover

This block moves the upper 32 bits of a floating-point register into or out of a 64-bit general-purpose value. It contains a 32-entry, 64-bit floating-point register array so it can be used and tested on its own. Each request gives a register-width mode bit, an operation (fetch-high or store-high), a 5-bit register index and a 64-bit general-purpose value. Fetch results are sign-extended to 64 bits and come back one cycle after the request.

Two register models are supported. In wide mode every register holds a full 64-bit value, and the high half is bits 63:32 of the addressed register. In paired mode an even/odd pair of registers forms one 64-bit value, and the high half is the low word of the next, odd register. In paired mode an odd index is illegal. A fetch then returns a fixed marker word, a store writes a different fixed marker word into the addressed register, and a warning pulse is raised.

A small state machine records what the last accepted request was. There are five states. ST_IDLE is entered when no request is present. ST_READ_DONE is entered after a legal fetch and ST_WRITE_DONE after a legal store. ST_ODD_READ and ST_ODD_WRITE are entered after an illegal paired-mode fetch or store. Every clock edge moves the machine from any state to exactly one of these five, chosen from the request sampled at that edge. The valid output is high in ST_READ_DONE and ST_ODD_READ. The warning output is high in ST_ODD_READ and ST_ODD_WRITE.

Top module: `fhm_hihalf_unit`

## Requirements
- R1: In wide mode (mode_wide=1), a fetch-high (req_op=0) drives gpr_out, in the cycle after the request, with bits 63:32 of the addressed register sign-extended to 64 bits, and gpr_valid is high in that cycle.
- R2: In paired mode (mode_wide=0) with an even index k, a fetch-high returns bits 31:0 of register k+1, sign-extended to 64 bits.
- R3: In paired mode with an odd index, a fetch-high returns 64'h0000_0000_0BAD_F00D, with gpr_valid high.
- R4: In wide mode, a store-high (req_op=1) writes gpr_in[31:0] into bits 63:32 of the addressed register and leaves its bits 31:0 unchanged.
- R5: In paired mode with an even index k, a store-high writes gpr_in[31:0] into bits 31:0 of register k+1 and leaves bits 63:32 of that register unchanged.
- R6: In paired mode with an odd index, a store-high writes 32'hDEAD_C0DE into bits 31:0 of the addressed register and leaves its bits 63:32 unchanged.
- R7: odd_warn is high for exactly the one cycle after a paired-mode request with an odd index, for either operation. It stays low after wide-mode requests and after even-index requests.
- R8: A store takes effect at the clock edge that samples it, so a fetch issued in the very next cycle returns the new value.
- R9: After reset every register reads as zero, and gpr_out, gpr_valid and odd_warn are all zero.
- R10: gpr_valid is low in the cycle after a store and in the cycle after a cycle with req_valid low. Inputs presented with req_valid low change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 1 | 0 = fetch high half, 1 = store high half |
| mode_wide | input | 1 | 1 = 64-bit registers, 0 = even/odd paired registers |
| fpr_idx | input | 5 | Floating-point register index |
| gpr_in | input | 64 | General-purpose value for stores (bits 31:0 used) |
| gpr_out | output | 64 | Sign-extended fetch result |
| gpr_valid | output | 1 | gpr_out holds a fresh fetch result |
| odd_warn | output | 1 | One-cycle pulse after an illegal odd paired-mode index |

## Verification
The hardest situation to reach from the ports is showing that a half-register write left the other half untouched. This is difficult because each mode exposes only one half of a register through a fetch. The stimulus therefore writes a register through one mode and reads it back through the other. A paired-mode store at an even index plants a low word in the odd partner register. A wide-mode store then replaces that register's high half, and a paired-mode fetch confirms the low word is still there. For the odd-index marker store, the upper word is first set in wide mode and then read back in wide mode after the marker is written.

// File: rtl/fhm_pkg.sv
package fhm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_DONE,
        ST_WRITE_DONE,
        ST_ODD_READ,
        ST_ODD_WRITE
    } fhm_state_e;

    localparam logic OP_FETCH = 1'b0;
    localparam logic OP_STORE = 1'b1;

    localparam logic [31:0] ODD_FETCH_MARK = 32'h0BAD_F00D;
    localparam logic [31:0] ODD_STORE_MARK = 32'hDEAD_C0DE;

endpackage

// File: rtl/fhm_route.sv
module fhm_route
    import fhm_pkg::*;
#(
    parameter int DW = 64,
    parameter int AW = 5,
    localparam int HW = DW / 2
) (
    input  logic          store_req,
    input  logic          mode_wide,
    input  logic [AW-1:0] idx,
    input  logic [HW-1:0] gpr_lo,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] phys_idx,
    output logic          odd_fault,
    output logic          we_hi,
    output logic          we_lo,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] fetch_val
);

    logic [HW-1:0] half_sel;

    always_comb begin
        odd_fault = !mode_wide && idx[0];
        // Wide mode addresses the register itself; paired mode the odd partner.
        phys_idx  = mode_wide ? idx : {idx[AW-1:1], 1'b1};
        we_hi     = store_req && mode_wide;
        we_lo     = store_req && !mode_wide;
        wdata     = {gpr_lo, (odd_fault ? ODD_STORE_MARK[HW-1:0] : gpr_lo)};
        if (odd_fault)
            half_sel = ODD_FETCH_MARK[HW-1:0];
        else if (mode_wide)
            half_sel = rdata[DW-1:HW];
        else
            half_sel = rdata[HW-1:0];
        fetch_val = {{HW{half_sel[HW-1]}}, half_sel};
    end

endmodule

// File: rtl/fhm_regfile.sv
module fhm_regfile #(
    parameter int NREG = 32,
    parameter int DW   = 64,
    localparam int AW  = $clog2(NREG),
    localparam int HW  = DW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_hi,
    input  logic          we_lo,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else begin
            if (we_hi) mem[addr][DW-1:HW] <= wdata[DW-1:HW];
            if (we_lo) mem[addr][HW-1:0]  <= wdata[HW-1:0];
        end
    end

    assign rdata = mem[addr];

    // R4
    half_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({we_hi, we_lo}));

    // R8
    hi_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_hi |=> mem[$past(addr)][DW-1:HW] == $past(wdata[DW-1:HW]));

    // R5
    lo_write_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_lo |=> mem[$past(addr)][DW-1:HW] == $past(rdata[DW-1:HW]));

endmodule

// File: rtl/fhm_hihalf_unit.sv
module fhm_hihalf_unit
    import fhm_pkg::*;
#(
    parameter int NREG = 32,
    parameter int DW   = 64,
    localparam int AW  = $clog2(NREG),
    localparam int HW  = DW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_op,
    input  logic          mode_wide,
    input  logic [AW-1:0] fpr_idx,
    input  logic [DW-1:0] gpr_in,
    output logic [DW-1:0] gpr_out,
    output logic          gpr_valid,
    output logic          odd_warn
);

    fhm_state_e    state_q, state_d;
    logic [AW-1:0] phys_idx;
    logic          odd_fault, we_hi, we_lo;
    logic [DW-1:0] wdata, rdata, fetch_val, result_q;
    logic          store_req, fetch_req;

    assign store_req = req_valid && (req_op == OP_STORE);
    assign fetch_req = req_valid && (req_op == OP_FETCH);

    fhm_route #(.DW(DW), .AW(AW)) u_route (
        .store_req (store_req),
        .mode_wide (mode_wide),
        .idx       (fpr_idx),
        .gpr_lo    (gpr_in[HW-1:0]),
        .rdata     (rdata),
        .phys_idx  (phys_idx),
        .odd_fault (odd_fault),
        .we_hi     (we_hi),
        .we_lo     (we_lo),
        .wdata     (wdata),
        .fetch_val (fetch_val)
    );

    fhm_regfile #(.NREG(NREG), .DW(DW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we_hi (we_hi),
        .we_lo (we_lo),
        .addr  (phys_idx),
        .wdata (wdata),
        .rdata (rdata)
    );

    always_comb begin
        if (!req_valid)
            state_d = ST_IDLE;
        else if (odd_fault)
            state_d = (req_op == OP_STORE) ? ST_ODD_WRITE : ST_ODD_READ;
        else
            state_d = (req_op == OP_STORE) ? ST_WRITE_DONE : ST_READ_DONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            result_q <= '0;
        end else begin
            state_q <= state_d;
            if (fetch_req) result_q <= fetch_val;
        end
    end

    always_comb begin
        gpr_valid = 1'b0;
        odd_warn  = 1'b0;
        unique case (state_q)
            ST_IDLE:       ;
            ST_READ_DONE:  gpr_valid = 1'b1;
            ST_WRITE_DONE: ;
            ST_ODD_READ:   begin gpr_valid = 1'b1; odd_warn = 1'b1; end
            ST_ODD_WRITE:  odd_warn = 1'b1;
            default:       ;
        endcase
    end

    assign gpr_out = result_q;

    // R1
    sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gpr_valid |-> gpr_out[DW-1:HW] == {HW{gpr_out[HW-1]}});

    // R7
    warn_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mode_wide && fpr_idx[0]) |=> odd_warn);

    // R7
    warn_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        odd_warn |-> $past(req_valid && !mode_wide && fpr_idx[0]));

    // R10
    valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gpr_valid |-> $past(req_valid && req_op == OP_FETCH));

endmodule

// File: tb/fhm_hihalf_unit_test.sv
module fhm_hihalf_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_op = 1'b0;
    logic        mode_wide = 1'b0;
    logic [4:0]  fpr_idx = '0;
    logic [63:0] gpr_in = '0;
    logic [63:0] gpr_out;
    logic        gpr_valid;
    logic        odd_warn;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [63:0] mdl [32];

    always #5 clk = ~clk;

    fhm_hihalf_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .mode_wide(mode_wide), .fpr_idx(fpr_idx), .gpr_in(gpr_in),
        .gpr_out(gpr_out), .gpr_valid(gpr_valid), .odd_warn(odd_warn)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [63:0] sx(input logic [31:0] w);
        return {{32{w[31]}}, w};
    endfunction

    function automatic logic [63:0] expect_fetch(input logic wide, input logic [4:0] idx);
        if (wide) return sx(mdl[idx][63:32]);
        if (idx[0]) return 64'h0000_0000_0BAD_F00D;
        return sx(mdl[idx + 5'd1][31:0]);
    endfunction

    // Drive one request; on return the outputs reflect it.
    task automatic send(input logic op, input logic wide, input logic [4:0] idx, input logic [63:0] g);
        req_valid = 1'b1; req_op = op; mode_wide = wide; fpr_idx = idx; gpr_in = g;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic fetch(input string tag, input logic wide, input logic [4:0] idx);
        send(1'b0, wide, idx, 64'h0);
        chk({tag, " value"}, gpr_out, expect_fetch(wide, idx));
        chk({tag, " valid"}, {63'h0, gpr_valid}, 64'h1);
        chk({tag, " warn"}, {63'h0, odd_warn}, {63'h0, (!wide && idx[0])});
    endtask

    task automatic store(input string tag, input logic wide, input logic [4:0] idx, input logic [63:0] g);
        send(1'b1, wide, idx, g);
        if (wide) mdl[idx][63:32] = g[31:0];
        else if (idx[0]) mdl[idx][31:0] = 32'hDEAD_C0DE;
        else mdl[idx + 5'd1][31:0] = g[31:0];
        chk({tag, " R10 no valid after store"}, {63'h0, gpr_valid}, 64'h0);
        chk({tag, " warn"}, {63'h0, odd_warn}, {63'h0, (!wide && idx[0])});
    endtask

    task automatic t_reset;
        chk("R9 gpr_out", gpr_out, 64'h0);
        chk("R9 valid", {63'h0, gpr_valid}, 64'h0);
        chk("R9 warn", {63'h0, odd_warn}, 64'h0);
        fetch("R9 wide reg7 zero", 1'b1, 5'd7);
        fetch("R9 paired reg13 zero", 1'b0, 5'd12);
    endtask

    task automatic t_wide;
        store("R4 wide store reg10", 1'b1, 5'd10, 64'hFFFF_FFFF_1234_5678);
        fetch("R1 wide fetch positive", 1'b1, 5'd10);
        store("R5 paired store plants reg3 lo", 1'b0, 5'd2, 64'h0000_0000_CAFE_0001);
        store("R4 wide store reg3 hi", 1'b1, 5'd3, 64'h0000_0000_8765_4321);
        fetch("R1 wide fetch negative", 1'b1, 5'd3);
        fetch("R4 low word kept", 1'b0, 5'd2);
    endtask

    task automatic t_paired;
        store("R5 paired store reg3 lo again", 1'b0, 5'd2, 64'h1111_1111_2468_ACE0);
        fetch("R2 paired fetch", 1'b0, 5'd2);
        fetch("R5 hi of reg3 kept", 1'b1, 5'd3);
        store("R2 paired store positive", 1'b0, 5'd20, 64'h0000_0000_7000_0001);
        fetch("R2 paired fetch positive", 1'b0, 5'd20);
    endtask

    task automatic t_odd;
        store("R6 wide set reg9 hi", 1'b1, 5'd9, 64'h0F0F_0F0F);
        store("R6 odd store reg9", 1'b0, 5'd9, 64'h5555_5555_1234_0000);
        fetch("R6 marker in reg9 lo", 1'b0, 5'd8);
        fetch("R6 reg9 hi kept", 1'b1, 5'd9);
        fetch("R3 odd fetch marker", 1'b0, 5'd13);
        @(negedge clk);
        chk("R7 warn one cycle only", {63'h0, odd_warn}, 64'h0);
        fetch("R7 wide odd no warn", 1'b1, 5'd13);
    endtask

    task automatic t_back_to_back;
        req_valid = 1'b1; req_op = 1'b1; mode_wide = 1'b1; fpr_idx = 5'd21; gpr_in = 64'h9ABC_DEF0;
        @(negedge clk);
        mdl[21][63:32] = 32'h9ABC_DEF0;
        req_op = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 fetch right after store", gpr_out, sx(32'h9ABC_DEF0));
        chk("R8 valid", {63'h0, gpr_valid}, 64'h1);
    endtask

    task automatic t_no_request;
        req_valid = 1'b0; req_op = 1'b1; mode_wide = 1'b1; fpr_idx = 5'd21; gpr_in = 64'h1;
        @(negedge clk);
        chk("R10 idle valid low", {63'h0, gpr_valid}, 64'h0);
        chk("R10 idle warn low", {63'h0, odd_warn}, 64'h0);
        fetch("R10 idle store ignored", 1'b1, 5'd21);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wide();
        t_paired();
        t_odd();
        t_back_to_back();
        t_no_request();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule